// File: doc/BRIEF.md
# Widening Saturating Scaled Multiply-Accumulator

This unit computes one element of a fixed-point multiply-accumulate that widens its result. Two narrow operands of SEW bits (8, 16 or 32) are multiplied to a full-width product. The product is shifted right by SEW/2 bits, and a rounding increment taken from the bits that fall off is added to it. The scaled value is then added to, or subtracted from, an accumulator that is 2*SEW bits wide, and the sum is clipped to the range of the accumulator's type. The clipped result replaces the accumulator element. A sticky flag records every clip until software-side control clears it.

A decoded 6-bit function code selects the operand signedness and the add or subtract direction. A 3-bit minor code picks the second operand from a vector register (vector-vector form) or from a scalar (vector-scalar form). A scalar is cut down to SEW bits before use. Each request enters on a valid/ready handshake and leaves one cycle later from an output register that holds its contents under back-pressure. A request the unit cannot execute still produces an output beat, marked illegal.

Back-pressure rules: the unit takes a request on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high while the output register is empty, or while the consumer is taking the current beat (`out_ready` high). A beat shown with `out_valid` high stays unchanged until `out_ready` is high at a rising edge.

Top module: `wsmac_unit`

## Requirements
- R1: The function code selects the operation. 111100: unsigned vs2 times unsigned operand, added, unsigned clip. 111101: signed times signed, added, signed clip. 111110: unsigned vs2 times signed operand, subtracted, signed clip. 111111: signed vs2 times unsigned operand, subtracted, signed clip. Minor code 000 takes the second operand from `in_vs1`, and 100 takes it from `in_scalar`.
- R2: `in_sew` 00, 01 and 10 select SEW of 8, 16 and 32. The full product is shifted right arithmetically by SEW/2 bits (4, 8 or 16).
- R3: The rounding increment depends on `in_rm`. 00 adds the highest shifted-out bit. 01 rounds to nearest, with ties going to the even value. 10 truncates. 11 sets the result LSB when any shifted-out bit is 1 and the LSB is 0.
- R4: In the unsigned function, a sum above 2^(2*SEW)-1 gives all ones in the low 2*SEW bits.
- R5: In the signed×signed function, a sum outside the signed 2*SEW range gives that range's maximum or minimum.
- R6: In both mixed-sign functions, the scaled product is subtracted from the accumulator, and the difference is clipped to the signed 2*SEW range.
- R7: In the scalar form, only the low SEW bits of `in_scalar` are used. They are signed for 111101 and 111110 and unsigned for 111100 and 111111.
- R8: `sat_flag` rises with the output beat of any clipped result. It stays high until a cycle where `sat_clr` is high and no new clip arrives, because a new clip takes priority over the clear.
- R9: A reserved `in_sew` (11), a function code outside 1111xx, a minor code other than 000 or 100, or function 111111 in the vector-vector form each produce a beat with `out_illegal` high and `out_result` zero. Such a beat leaves `sat_flag` unchanged.
- R10: `in_ready` equals NOT `out_valid` OR `out_ready`. An accepted request appears on the outputs at the next edge. A beat that has not been taken is held stable.
- R11: After reset, `out_valid` and `sat_flag` are low.
- R12: In `out_result`, the bits above 2*SEW are zero, whatever the upper bits of `in_acc` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_func | input | 6 | Decoded function code |
| in_minor | input | 3 | Form code: 000 vector-vector, 100 vector-scalar |
| in_sew | input | 2 | Element width select |
| in_rm | input | 2 | Fixed-point rounding mode |
| in_vs2 | input | 32 | First narrow operand (low SEW bits used) |
| in_vs1 | input | 32 | Second narrow operand, vector form |
| in_scalar | input | 64 | Second narrow operand, scalar form |
| in_acc | input | 64 | Accumulator (low 2*SEW bits used) |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_result | output | 64 | Clipped result, zero-extended above 2*SEW |
| out_illegal | output | 1 | Beat carries an illegal request |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions rely on every request field being driven to a known value, both while `in_valid` is high and at the edge where the request is taken. They also rely on `out_ready` and `sat_clr` being known on every edge after reset. The bench drives every field on every cycle, including idle ones, and changes inputs only on the falling clock edge. It toggles `out_ready` at random during the long random phase, so that beats which have not been taken are exercised alongside back-to-back transfers. Reserved width codes and invalid function and minor codes are mixed into the random requests, so the illegal path is checked with all other fields known.

// File: rtl/wsmac_pkg.sv
package wsmac_pkg;

  typedef enum logic [5:0] {
    FN_UU = 6'b111100,
    FN_SS = 6'b111101,
    FN_SU = 6'b111110,
    FN_US = 6'b111111
  } fn_e;

  localparam logic [2:0] MN_VV = 3'b000;
  localparam logic [2:0] MN_VX = 3'b100;

  typedef enum logic [1:0] {
    RM_NEAR_UP   = 2'b00,
    RM_NEAR_EVEN = 2'b01,
    RM_DOWN      = 2'b10,
    RM_ODD       = 2'b11
  } rmode_e;

  typedef struct packed {
    logic illegal;
    logic a_signed;
    logic b_signed;
    logic acc_signed;
    logic subtract;
    logic use_scalar;
  } op_ctl_t;

endpackage

// File: rtl/wsmac_decode.sv
module wsmac_decode
  import wsmac_pkg::*;
#(
  parameter int NSEW = 3
) (
  input  logic [5:0] func,
  input  logic [2:0] minor,
  input  logic [1:0] sew,
  output op_ctl_t    ctl
);

  logic is_vv, is_vx, bad_fn;

  always_comb begin
    ctl    = '0;
    bad_fn = 1'b0;
    is_vv  = (minor == MN_VV);
    is_vx  = (minor == MN_VX);
    case (func)
      FN_UU: ;
      FN_SS: begin
        ctl.a_signed   = 1'b1;
        ctl.b_signed   = 1'b1;
        ctl.acc_signed = 1'b1;
      end
      FN_SU: begin
        ctl.b_signed   = 1'b1;
        ctl.acc_signed = 1'b1;
        ctl.subtract   = 1'b1;
      end
      FN_US: begin
        ctl.a_signed   = 1'b1;
        ctl.acc_signed = 1'b1;
        ctl.subtract   = 1'b1;
      end
      default: bad_fn = 1'b1;
    endcase
    ctl.use_scalar = is_vx;
    ctl.illegal    = bad_fn | ~(is_vv | is_vx) | ((func == FN_US) & is_vv)
                   | (int'(sew) >= NSEW);
  end

endmodule

// File: rtl/wsmac_round.sv
module wsmac_round
  import wsmac_pkg::*;
#(
  parameter int W = 18,
  parameter int D = 4
) (
  input  logic signed [W-1:0] val,
  input  logic        [1:0]   rm,
  output logic signed [W-1:0] scaled
);

  logic signed [W-1:0] shr;
  logic half, rest, lsb, inc;

  always_comb begin
    shr  = val >>> D;
    half = val[D-1];
    rest = |val[D-2:0];
    lsb  = val[D];
    case (rmode_e'(rm))
      RM_NEAR_UP:   inc = half;
      RM_NEAR_EVEN: inc = half & (rest | lsb);
      RM_DOWN:      inc = 1'b0;
      default:      inc = ~lsb & (half | rest);
    endcase
    scaled = shr + $signed({{(W-1){1'b0}}, inc});
  end

endmodule

// File: rtl/wsmac_lane.sv
module wsmac_lane #(
  parameter int S = 8
) (
  input  logic [S-1:0]   a,
  input  logic [S-1:0]   b,
  input  logic [2*S-1:0] acc,
  input  logic           a_signed,
  input  logic           b_signed,
  input  logic           acc_signed,
  input  logic           subtract,
  input  logic [1:0]     rm,
  output logic [2*S-1:0] res,
  output logic           sat
);

  localparam int D  = S / 2;
  localparam int PW = 2 * S + 2;
  localparam int AW = PW + 1;
  localparam logic signed [AW-1:0] ONE  = AW'(1);
  localparam logic signed [AW-1:0] ZERO = '0;
  localparam logic signed [AW-1:0] SMAX = (ONE <<< (2 * S - 1)) - ONE;
  localparam logic signed [AW-1:0] SMIN = -(ONE <<< (2 * S - 1));
  localparam logic signed [AW-1:0] UMAX = (ONE <<< (2 * S)) - ONE;

  logic signed [S:0]    ax, bx;
  logic signed [PW-1:0] prod, scaled;
  logic signed [AW-1:0] accx, prodx, sum, hi, lo;

  assign ax   = {a_signed & a[S-1], a};
  assign bx   = {b_signed & b[S-1], b};
  assign prod = ax * bx;

  wsmac_round #(.W(PW), .D(D)) u_round (
    .val    (prod),
    .rm     (rm),
    .scaled (scaled)
  );

  always_comb begin
    accx  = {{3{acc_signed & acc[2*S-1]}}, acc};
    prodx = {scaled[PW-1], scaled};
    sum   = subtract ? (accx - prodx) : (accx + prodx);
    hi    = acc_signed ? SMAX : UMAX;
    lo    = acc_signed ? SMIN : ZERO;
    sat   = 1'b1;
    if (sum > hi)      res = hi[2*S-1:0];
    else if (sum < lo) res = lo[2*S-1:0];
    else begin
      res = sum[2*S-1:0];
      sat = 1'b0;
    end
  end

endmodule

// File: rtl/wsmac_unit.sv
module wsmac_unit
  import wsmac_pkg::*;
#(
  parameter int MIN_SEW = 8,
  parameter int NSEW    = 3,
  parameter int XLEN    = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [5:0]                    in_func,
  input  logic [2:0]                    in_minor,
  input  logic [1:0]                    in_sew,
  input  logic [1:0]                    in_rm,
  input  logic [(MIN_SEW<<(NSEW-1))-1:0]   in_vs2,
  input  logic [(MIN_SEW<<(NSEW-1))-1:0]   in_vs1,
  input  logic [XLEN-1:0]               in_scalar,
  input  logic [2*(MIN_SEW<<(NSEW-1))-1:0] in_acc,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [2*(MIN_SEW<<(NSEW-1))-1:0] out_result,
  output logic                          out_illegal,
  input  logic                          sat_clr,
  output logic                          sat_flag
);

  localparam int MAX_SEW = MIN_SEW << (NSEW - 1);
  localparam int RW      = 2 * MAX_SEW;

  op_ctl_t           ctl;
  logic [RW-1:0]     lane_res [NSEW];
  logic [NSEW-1:0]   lane_sat;
  logic [RW-1:0]     sel_res;
  logic              sel_sat;
  logic              accept;
  logic              unused_scalar_hi;

  assign unused_scalar_hi = ^in_scalar[XLEN-1:MAX_SEW];

  wsmac_decode #(.NSEW(NSEW)) u_decode (
    .func  (in_func),
    .minor (in_minor),
    .sew   (in_sew),
    .ctl   (ctl)
  );

  for (genvar gi = 0; gi < NSEW; gi++) begin : g_lane
    localparam int S = MIN_SEW << gi;
    logic [S-1:0]   b_pick;
    logic [2*S-1:0] r;
    assign b_pick = ctl.use_scalar ? in_scalar[S-1:0] : in_vs1[S-1:0];
    wsmac_lane #(.S(S)) u_lane (
      .a          (in_vs2[S-1:0]),
      .b          (b_pick),
      .acc        (in_acc[2*S-1:0]),
      .a_signed   (ctl.a_signed),
      .b_signed   (ctl.b_signed),
      .acc_signed (ctl.acc_signed),
      .subtract   (ctl.subtract),
      .rm         (in_rm),
      .res        (r),
      .sat        (lane_sat[gi])
    );
    assign lane_res[gi] = RW'(r);
  end

  always_comb begin
    sel_res = '0;
    sel_sat = 1'b0;
    for (int i = 0; i < NSEW; i++) begin
      if (int'(in_sew) == i) begin
        sel_res = lane_res[i];
        sel_sat = lane_sat[i];
      end
    end
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
      sat_flag    <= 1'b0;
    end else begin
      if (accept) begin
        out_valid   <= 1'b1;
        out_result  <= ctl.illegal ? '0 : sel_res;
        out_illegal <= ctl.illegal;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      sat_flag <= (sat_flag & ~sat_clr) | (accept & ~ctl.illegal & sel_sat);
    end
  end

endmodule

// File: rtl/wsmac_checks.sv
module wsmac_checks #(
  parameter int RW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_sew,
  input logic          out_valid,
  input logic          out_ready,
  input logic [RW-1:0] out_result,
  input logic          out_illegal,
  input logic          sat_clr,
  input logic          sat_flag
);

  a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal));

  a_r10_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r8_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clr |=> sat_flag);

  a_r8_sticky_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(in_valid && in_ready));

  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0);

  a_r9_reserved_width: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_sew == 2'b11 |=> out_valid && out_illegal);

endmodule

bind wsmac_unit wsmac_checks u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_sew      (in_sew),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal),
  .sat_clr     (sat_clr),
  .sat_flag    (sat_flag)
);

// File: tb/wsmac_unit_bench.sv
module wsmac_unit_bench;

  typedef logic signed [127:0] w_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_func = '0;
  logic [2:0]  in_minor = '0;
  logic [1:0]  in_sew = '0;
  logic [1:0]  in_rm = '0;
  logic [31:0] in_vs2 = '0;
  logic [31:0] in_vs1 = '0;
  logic [63:0] in_scalar = '0;
  logic [63:0] in_acc = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_result;
  logic        out_illegal;
  logic        sat_clr = 1'b0;
  logic        sat_flag;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 0;
  bit    m_valid  = 0;
  bit    m_ill    = 0;
  bit    m_sticky = 0;
  logic [63:0] m_res = '0;
  string m_tag = "R1";

  always #5 clk = ~clk;

  wsmac_unit u_wsmac_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_func(in_func), .in_minor(in_minor), .in_sew(in_sew), .in_rm(in_rm),
    .in_vs2(in_vs2), .in_vs1(in_vs1), .in_scalar(in_scalar), .in_acc(in_acc),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_illegal(out_illegal), .sat_clr(sat_clr), .sat_flag(sat_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic w_t low_mask(input int n);
    return (w_t'(1) << n) - w_t'(1);
  endfunction

  // Behavioural reference for one request, from the requirements.
  function automatic void ref_op(input logic [5:0] f, input logic [2:0] mn, input logic [1:0] sw,
                                 input logic [1:0] rm, input logic [31:0] a, input logic [31:0] b,
                                 input logic [63:0] sc, input logic [63:0] acc,
                                 output logic [63:0] res, output bit sat, output bit ill);
    int S, D;
    bit sa, sb, sacc, sub, half, rest, lsb, inc;
    w_t av, bv, p, sh, ac, r, hi, lo;
    ill = (sw == 2'b11) || (f[5:2] != 4'b1111) || (mn != 3'b000 && mn != 3'b100)
          || (f == 6'b111111 && mn == 3'b000);
    res = '0;
    sat = 0;
    if (ill) return;
    S    = 8 << sw;
    D    = S / 2;
    sa   = (f == 6'b111101) || (f == 6'b111111);
    sb   = (f == 6'b111101) || (f == 6'b111110);
    sacc = (f != 6'b111100);
    sub  = f[1];
    av = w_t'(a) & low_mask(S);
    if (sa && av[S-1]) av = av - (w_t'(1) << S);
    bv = w_t'((mn == 3'b100) ? sc[31:0] : b) & low_mask(S);
    if (sb && bv[S-1]) bv = bv - (w_t'(1) << S);
    p    = av * bv;
    sh   = p >>> D;
    half = p[D-1];
    rest = (p & low_mask(D-1)) != 0;
    lsb  = sh[0];
    case (rm)
      2'b00: inc = half;
      2'b01: inc = half && (rest || lsb);
      2'b10: inc = 0;
      default: inc = !lsb && (half || rest);
    endcase
    sh = sh + (inc ? w_t'(1) : w_t'(0));
    ac = w_t'(acc) & low_mask(2*S);
    if (sacc && ac[2*S-1]) ac = ac - (w_t'(1) << (2*S));
    r  = sub ? ac - sh : ac + sh;
    hi = sacc ? (w_t'(1) << (2*S-1)) - 1 : low_mask(2*S);
    lo = sacc ? -(w_t'(1) << (2*S-1)) : w_t'(0);
    if (r > hi) begin r = hi; sat = 1; end
    else if (r < lo) begin r = lo; sat = 1; end
    res = 64'(r & low_mask(2*S));
  endfunction

  // One clock: compare outputs with the model, drive, predict the next edge.
  task automatic step(input bit v, input logic [5:0] f, input logic [2:0] mn, input logic [1:0] sw,
                      input logic [1:0] rm, input logic [31:0] a, input logic [31:0] b,
                      input logic [63:0] sc, input logic [63:0] acc, input bit ordy, input bit clr,
                      input string tag);
    logic [63:0] r;
    bit s, il, exp_rdy;
    chk(out_valid === m_valid, "R10", 64'(out_valid), 64'(m_valid));
    if (m_valid) begin
      chk(out_result === m_res, m_tag, out_result, m_res);
      chk(out_illegal === m_ill, m_ill ? "R9" : m_tag, 64'(out_illegal), 64'(m_ill));
    end
    chk(sat_flag === m_sticky, "R8", 64'(sat_flag), 64'(m_sticky));
    in_valid = v; in_func = f; in_minor = mn; in_sew = sw; in_rm = rm;
    in_vs2 = a; in_vs1 = b; in_scalar = sc; in_acc = acc;
    out_ready = ordy; sat_clr = clr;
    #1;
    exp_rdy = !m_valid || ordy;
    chk(in_ready === exp_rdy, "R10", 64'(in_ready), 64'(exp_rdy));
    ref_op(f, mn, sw, rm, a, b, sc, acc, r, s, il);
    if (v && exp_rdy) begin
      m_valid  = 1;
      m_res    = r;
      m_ill    = il;
      m_tag    = tag;
      m_sticky = (m_sticky && !clr) || (!il && s);
    end else begin
      if (ordy) m_valid = 0;
      m_sticky = m_sticky && !clr;
    end
    @(negedge clk);
  endtask

  task automatic op(input logic [5:0] f, input logic [2:0] mn, input logic [1:0] sw, input logic [1:0] rm,
                    input logic [31:0] a, input logic [31:0] b, input logic [63:0] sc,
                    input logic [63:0] acc, input string tag);
    step(1, f, mn, sw, rm, a, b, sc, acc, 1, 0, tag);
  endtask

  task automatic idle(input bit clr);
    step(0, 6'h3c, 3'b000, 2'b00, 2'b00, '0, '0, '0, '0, 1, clr, "R8");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] hr;
    bit hs, hi_;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R11", 64'(out_valid), 64'd0);
    chk(sat_flag === 1'b0, "R11", 64'(sat_flag), 64'd0);

    // Hand-worked values fix the model: 255*255=65025, >>4 truncated = 4064.
    ref_op(6'h3c, 3'b000, 2'b00, 2'b10, 32'hff, 32'hff, '0, '0, hr, hs, hi_);
    chk(hr == 64'd4064, "R2", hr, 64'd4064);
    // 3*8=24=0b11000: nearest-even on a tie with odd LSB rounds up to 2.
    ref_op(6'h3d, 3'b000, 2'b00, 2'b01, 32'd3, 32'd8, '0, '0, hr, hs, hi_);
    chk(hr == 64'd2, "R3", hr, 64'd2);

    // R2 width scaling
    op(6'h3c, 3'b000, 2'b00, 2'b10, 32'hff, 32'hff, '0, '0, "R2");
    op(6'h3c, 3'b000, 2'b01, 2'b10, 32'hffff, 32'h1234, '0, 64'd77, "R2");
    op(6'h3c, 3'b000, 2'b10, 2'b10, 32'hdeadbeef, 32'h12345678, '0, 64'd5, "R2");
    // R3 rounding modes on ties, above-half and negative products
    for (int m = 0; m < 4; m++) begin
      op(6'h3d, 3'b000, 2'b00, 2'(m), 32'd3, 32'd3, '0, '0, "R3");
      op(6'h3d, 3'b000, 2'b00, 2'(m), 32'd1, 32'd8, '0, '0, "R3");
      op(6'h3d, 3'b000, 2'b00, 2'(m), 32'd3, 32'd8, '0, '0, "R3");
      op(6'h3d, 3'b000, 2'b00, 2'(m), 32'hfd, 32'd3, '0, '0, "R3");
      op(6'h3d, 3'b000, 2'b01, 2'(m), 32'hff80, 32'h0003, '0, 64'd9, "R3");
    end
    // R4 unsigned clip, then R8 sticky behaviour
    op(6'h3c, 3'b000, 2'b00, 2'b00, 32'hff, 32'hff, '0, 64'hfff0, "R4");
    idle(0); idle(0);
    idle(1); idle(0);
    step(1, 6'h3c, 3'b000, 2'b00, 2'b00, 32'hff, 32'hff, '0, 64'hffff, 1, 1, "R8");
    idle(0); idle(1); idle(0);
    // R5 signed clips both ways
    op(6'h3d, 3'b000, 2'b01, 2'b00, 32'h7fff, 32'h7fff, '0, 64'h7fffff00, "R5");
    op(6'h3d, 3'b000, 2'b01, 2'b00, 32'h8000, 32'h7fff, '0, 64'h80000000, "R5");
    op(6'h3d, 3'b000, 2'b10, 2'b01, 32'h80000000, 32'h80000000, '0, 64'h7fffffffffffff00, "R5");
    idle(1);
    // R6 mixed-sign subtraction
    op(6'h3e, 3'b000, 2'b00, 2'b00, 32'hff, 32'h7f, '0, 64'h8000, "R6");
    op(6'h3f, 3'b100, 2'b00, 2'b00, 32'h80, '0, 64'hff, 64'h7fff, "R6");
    op(6'h3e, 3'b000, 2'b01, 2'b11, 32'h1234, 32'hff00, '0, 64'h100, "R6");
    op(6'h3f, 3'b100, 2'b10, 2'b01, 32'h7fffffff, '0, 64'hffffffff, 64'h1, "R6");
    idle(1);
    // R7 scalar truncation and sign treatment
    op(6'h3d, 3'b100, 2'b00, 2'b00, 32'h10, 32'h55, 64'habcd123456789a80, 64'd0, "R7");
    op(6'h3c, 3'b100, 2'b00, 2'b00, 32'h10, 32'h55, 64'habcd123456789a80, 64'd0, "R7");
    op(6'h3e, 3'b100, 2'b01, 2'b00, 32'h10, 32'h55, 64'h0000ffff0000f000, 64'd0, "R7");
    op(6'h3f, 3'b100, 2'b01, 2'b00, 32'hfff0, 32'h55, 64'h12340000ffff, 64'd0, "R7");
    // R12 upper accumulator bits ignored, upper result bits zero
    op(6'h3d, 3'b000, 2'b00, 2'b00, 32'hffffff12, 32'hffffff34, '0, 64'hdeadbeefcafe0042, "R12");
    op(6'h3c, 3'b000, 2'b01, 2'b00, 32'hffff0012, 32'h00340034, '0, 64'hdeadbeef00000042, "R12");
    idle(1);
    // R9 illegal requests leave the sticky flag alone
    op(6'h3c, 3'b000, 2'b11, 2'b00, 32'hff, 32'hff, '0, 64'hffff, "R9");
    op(6'h2a, 3'b000, 2'b00, 2'b00, 32'hff, 32'hff, '0, 64'hffff, "R9");
    op(6'h3c, 3'b010, 2'b00, 2'b00, 32'hff, 32'hff, '0, 64'hffff, "R9");
    op(6'h3f, 3'b000, 2'b00, 2'b00, 32'h80, 32'hff, 64'hff, 64'h7fff, "R9");
    idle(0); idle(0);
    // R1 and R10: random requests under random back-pressure
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] f;
      logic [2:0] mn;
      logic [1:0] sw;
      f  = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'(6'h3c + $urandom_range(0, 3));
      mn = ($urandom_range(0, 9) == 0) ? 3'($urandom) : ($urandom_range(0, 1) ? 3'b100 : 3'b000);
      sw = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
      step($urandom_range(0, 3) != 0, f, mn, sw, 2'($urandom),
           $urandom, $urandom, {$urandom, $urandom}, {$urandom, $urandom},
           $urandom_range(0, 2) != 0, $urandom_range(0, 15) == 0, "R1");
    end
    step(0, 6'h3c, 3'b000, 2'b00, 2'b00, '0, '0, '0, '0, 1, 0, "R10");
    step(0, 6'h3c, 3'b000, 2'b00, 2'b00, '0, '0, '0, '0, 1, 0, "R10");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule